// File: doc/BRIEF.md
# Dual-Output Programmable Clock Divider Chain

This block derives two synchronous clock waveforms from one master clock. The reference output is either the master clock itself or the master clock divided by a selectable power of two (1, 2, 4 or 8). The main output passes through its own power-of-two prescaler. It then either goes through an integer divider whose divisor is the programmed 10-bit word plus two, or it bypasses that divider.

The block runs on a timing clock `clk` at twice the master rate, so one master period spans two `clk` cycles. An output that divides the master clock by D therefore has a half period of exactly D `clk` cycles. Every divisor, odd ones included, gives an exact 50% duty cycle. Each output has an enable flag that stands in for the high-impedance pad state. Each output also has a small gating state machine that starts the waveform at a fixed latency and removes the enable only once the waveform is low.

Gating machine states: `GATE_IDLE` (flag off, generator held clear), `GATE_RUN` (flag on, generator running) and `GATE_DRAIN` (request withdrawn, waiting for a low level). Its transitions are as follows:
- IDLE→RUN when a request is seen.
- RUN→DRAIN when the request drops.
- DRAIN→RUN when the request returns.
- DRAIN→IDLE when the output is low and not about to rise, or when it is high and falls on that same edge.

The phase generator has the states `PH_LOW` and `PH_HIGH`. It swaps between them each time its half-period counter expires.

Top module: `dual_clk_chain`

## Requirements
- R1: A prescaler code of 00, 01, 10 or 11 selects a prescale factor of 1, 2, 4 or 8.
- R2: With the divider in use, the main output half period is (word + 2) × prescale `clk` cycles, for words from 0 to 1023.
- R3: With `main_div_skip` = 1, the main half period equals the prescale factor, and the value of `main_div_word` has no effect.
- R4: With `ref_psc_use` = 0, the reference half period is 1 `clk` cycle (the master clock undivided). With `ref_psc_use` = 1, the half period equals the reference prescale factor.
- R5: After an enable request is withdrawn, the output enable flag stays set until the output is low. A high phase already in progress is never shortened. While the flag is clear, the output is low.
- R6: An enable request sampled at a `clk` edge sets the flag at that edge and leaves the output low. The first rising output edge follows exactly one half period later, so the delay from request to rise is constant for a given setting.
- R7: The high and low phases of every output period are equal in length.
- R8: A new divisor, prescale or bypass setting is taken up only at a rising output edge. The period that starts at the first rise after the change uses the new setting, and the period in progress keeps its old length.
- R9: During and after reset, with no requests, both enable flags are 0 and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock, twice the master rate |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_psc_sel | input | 2 | Reference prescale code |
| main_psc_sel | input | 2 | Main prescale code |
| main_div_word | input | 10 | Main divider word (divisor = word + 2) |
| main_div_skip | input | 1 | 1: bypass the main divider |
| ref_psc_use | input | 1 | 1: reference uses its prescaler, 0: undivided |
| ref_en | input | 1 | Reference enable request |
| main_en | input | 1 | Main enable request |
| ref_clk_o | output | 1 | Reference clock waveform |
| ref_oe | output | 1 | Reference output enable flag |
| main_clk_o | output | 1 | Main clock waveform |
| main_oe | output | 1 | Main output enable flag |

## Verification
A corrupted half-period counter or a wrongly latched length shows up at the output within one period. The high or low phase then differs from the computed length, or the two phases differ from each other. A gating machine stuck in the wrong state shows at the flag within a half period. It appears as a flag that drops while the output is high, a flag that never sets, or a first rising edge that arrives one or more cycles away from the fixed latency. A setting taken up at the wrong moment shows up as a shortened or stretched phase in the period during which the setting was changed.

// File: rtl/clk_chain_pkg.sv
package clk_chain_pkg;

    typedef enum logic [1:0] {
        GATE_IDLE  = 2'd0,
        GATE_RUN   = 2'd1,
        GATE_DRAIN = 2'd2
    } gate_state_e;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

endpackage

// File: rtl/clk_phase_gen.sv
module clk_phase_gen
    import clk_chain_pkg::*;
#(
    parameter int LEN_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [LEN_W-1:0] len_in,
    output logic             wave,
    output logic             flip_next
);

    phase_e           phase, phase_nxt;
    logic [LEN_W-1:0] cnt, cnt_nxt;
    logic [LEN_W-1:0] cur_len, cur_len_nxt;

    // Half period expires on this edge
    assign flip_next = run && (cnt == cur_len - 1'b1);

    always_comb begin
        phase_nxt   = phase;
        cnt_nxt     = cnt + 1'b1;
        cur_len_nxt = cur_len;
        if (!run) begin
            phase_nxt   = PH_LOW;
            cnt_nxt     = '0;
            cur_len_nxt = len_in;
        end else if (flip_next) begin
            cnt_nxt = '0;
            unique case (phase)
                PH_LOW: begin
                    phase_nxt   = PH_HIGH;
                    cur_len_nxt = len_in;      // new setting only at a rise
                end
                PH_HIGH: phase_nxt = PH_LOW;
                default: phase_nxt = PH_LOW;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_LOW;
            cnt     <= '0;
            cur_len <= {{(LEN_W-1){1'b0}}, 1'b1};
        end else begin
            phase   <= phase_nxt;
            cnt     <= cnt_nxt;
            cur_len <= cur_len_nxt;
        end
    end

    always_comb begin
        wave = (phase == PH_HIGH);
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < cur_len); // R2

    AST_LEN_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && (cur_len != $past(cur_len))) |-> $rose(wave)); // R8

endmodule

// File: rtl/clk_out_gate.sv
module clk_out_gate
    import clk_chain_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic wave,
    input  logic flip_next,
    output logic run,
    output logic oe
);

    gate_state_e state, state_nxt;
    logic        safe_stop;

    // Stopping is safe when low and staying low, or when the high phase ends now
    assign safe_stop = (wave && flip_next) || (!wave && !flip_next);

    always_comb begin
        state_nxt = state;
        unique case (state)
            GATE_IDLE:  state_nxt = req ? GATE_RUN : GATE_IDLE;
            GATE_RUN:   state_nxt = req ? GATE_RUN : GATE_DRAIN;
            GATE_DRAIN: begin
                if (req)            state_nxt = GATE_RUN;
                else if (safe_stop) state_nxt = GATE_IDLE;
                else                state_nxt = GATE_DRAIN;
            end
            default:    state_nxt = GATE_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= GATE_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        oe  = (state != GATE_IDLE);
        run = (state != GATE_IDLE);
    end

    AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> !wave); // R5

    AST_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |-> !wave); // R6

    AST_DRAIN_HOLDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == GATE_DRAIN && !req && wave && !flip_next) |=> oe); // R5

endmodule

// File: rtl/dual_clk_chain.sv
module dual_clk_chain
    import clk_chain_pkg::*;
#(
    parameter int WORD_W  = 10,
    parameter int PSC_W   = 2,
    parameter int DIV_OFS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PSC_W-1:0]  ref_psc_sel,
    input  logic [PSC_W-1:0]  main_psc_sel,
    input  logic [WORD_W-1:0] main_div_word,
    input  logic              main_div_skip,
    input  logic              ref_psc_use,
    input  logic              ref_en,
    input  logic              main_en,
    output logic              ref_clk_o,
    output logic              ref_oe,
    output logic              main_clk_o,
    output logic              main_oe
);

    localparam int N_CH   = 2;
    localparam int MAX_SH = (1 << PSC_W) - 1;
    localparam int LEN_W  = WORD_W + 1 + MAX_SH;
    localparam int CH_REF = 0;
    localparam int CH_MAIN = 1;

    logic [N_CH-1:0]            req_a, wave_a, flip_a, run_a, oe_a;
    logic [N_CH-1:0][LEN_W-1:0] len_a;

    assign req_a[CH_REF]  = ref_en;
    assign req_a[CH_MAIN] = main_en;

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        if (ch == CH_MAIN) begin : g_len_main
            always_comb begin
                if (main_div_skip)
                    len_a[ch] = LEN_W'(1) << main_psc_sel;
                else
                    len_a[ch] = (LEN_W'(main_div_word) + LEN_W'(DIV_OFS)) << main_psc_sel;
            end
        end else begin : g_len_ref
            always_comb begin
                if (ref_psc_use) len_a[ch] = LEN_W'(1) << ref_psc_sel;
                else             len_a[ch] = LEN_W'(1);
            end
        end

        clk_phase_gen #(.LEN_W(LEN_W)) u_gen (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (run_a[ch]),
            .len_in    (len_a[ch]),
            .wave      (wave_a[ch]),
            .flip_next (flip_a[ch])
        );

        clk_out_gate u_gate (
            .clk       (clk),
            .rst_n     (rst_n),
            .req       (req_a[ch]),
            .wave      (wave_a[ch]),
            .flip_next (flip_a[ch]),
            .run       (run_a[ch]),
            .oe        (oe_a[ch])
        );
    end

    assign ref_clk_o  = wave_a[CH_REF];
    assign ref_oe     = oe_a[CH_REF];
    assign main_clk_o = wave_a[CH_MAIN];
    assign main_oe    = oe_a[CH_MAIN];

    AST_REF_DIRECT_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ref_oe) && ref_oe && $past(ref_oe, 2) && !ref_psc_use
         && !$past(ref_psc_use) && !$past(ref_psc_use, 2) && !$past(ref_en, 1) == 1'b0
         && $past(ref_clk_o) && $past(ref_clk_o) != $past(ref_clk_o, 2))
        |-> !ref_clk_o); // R4

endmodule

// File: tb/dual_clk_chain_test.sv
module dual_clk_chain_test;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_LIMIT = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ref_psc_sel = 2'b00, main_psc_sel = 2'b00;
    logic [9:0] main_div_word = '0;
    logic       main_div_skip = 1'b0, ref_psc_use = 1'b0;
    logic       ref_en = 1'b0, main_en = 1'b0;
    logic       ref_clk_o, ref_oe, main_clk_o, main_oe;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 0;

    typedef struct {
        int    ch;
        int    half;
        string tag;
    } item_t;

    item_t exp_q[$];
    bit    mon_busy = 0;

    dual_clk_chain uut (
        .clk(clk), .rst_n(rst_n),
        .ref_psc_sel(ref_psc_sel), .main_psc_sel(main_psc_sel),
        .main_div_word(main_div_word), .main_div_skip(main_div_skip),
        .ref_psc_use(ref_psc_use), .ref_en(ref_en), .main_en(main_en),
        .ref_clk_o(ref_clk_o), .ref_oe(ref_oe),
        .main_clk_o(main_clk_o), .main_oe(main_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG_LIMIT) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WDOG_LIMIT);
            finish_run();
        end
    end

    function automatic logic smp(input int ch);
        return (ch == 1) ? main_clk_o : ref_clk_o;
    endfunction

    // Measure one full period starting at the next rising edge
    task automatic measure(input int ch, output int hi, output int lo);
        @(negedge clk);
        while (smp(ch) !== 1'b0) @(negedge clk);
        while (smp(ch) !== 1'b1) @(negedge clk);
        hi = 0;
        while (smp(ch) === 1'b1) begin hi++; @(negedge clk); end
        lo = 0;
        while (smp(ch) === 1'b0) begin lo++; @(negedge clk); end
    endtask

    // Monitor: pops expectations and compares them with measured periods
    initial begin
        forever begin
            wait (exp_q.size() > 0);
            mon_busy = 1;
            begin
                item_t it;
                int hi, lo;
                it = exp_q.pop_front();
                measure(it.ch, hi, lo);
                check(it.tag, hi, it.half);
                check("R7 low equals high", lo, hi);
            end
            mon_busy = 0;
        end
    end

    // Driver side: push expectation and wait for the monitor
    task automatic expect_period(input int ch, input int half, input string tag);
        item_t it;
        it.ch = ch; it.half = half; it.tag = tag;
        exp_q.push_back(it);
        wait (exp_q.size() == 0 && !mon_busy);
    endtask

    task automatic wait_main_off();
        @(negedge clk);
        while (main_oe !== 1'b0) @(negedge clk);
    endtask

    initial begin
        int k, hi, lo;
        bit seen_high;

        // R9: reset state
        repeat (3) @(negedge clk);
        check("R9 ref_oe in reset", int'(ref_oe), 0);
        check("R9 main_oe in reset", int'(main_oe), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R9 ref_clk idle", int'(ref_clk_o), 0);
        check("R9 main_clk idle", int'(main_clk_o), 0);
        check("R9 main_oe idle", int'(main_oe), 0);

        // R4: reference undivided, then prescaled (R1)
        ref_en = 1'b1;
        expect_period(0, 1, "R4 ref undivided");
        ref_psc_use = 1'b1; ref_psc_sel = 2'b01;
        expect_period(0, 2, "R1 ref code 01");
        ref_psc_sel = 2'b10;
        expect_period(0, 4, "R1 ref code 10");
        ref_psc_sel = 2'b11;
        expect_period(0, 8, "R1 ref code 11");
        ref_psc_sel = 2'b00;
        expect_period(0, 1, "R4 ref prescaler code 00");

        // R2: main divider words
        main_en = 1'b1;
        expect_period(1, 2, "R2 main word 0");
        main_div_word = 10'd1;
        expect_period(1, 3, "R2 R7 main word 1 odd");
        main_div_word = 10'd1023;
        expect_period(1, 1025, "R2 main word 1023");
        main_psc_sel = 2'b11; main_div_word = 10'd5;
        expect_period(1, 56, "R1 R2 main code 11 word 5");

        // R3: bypass ignores the word
        main_div_skip = 1'b1; main_psc_sel = 2'b10; main_div_word = 10'd1023;
        expect_period(1, 4, "R3 bypass code 10");
        main_div_word = 10'd7;
        expect_period(1, 4, "R3 word ignored in bypass");

        // R6: fixed enable latency (half = 5, latency 6 samples)
        main_en = 1'b0;
        wait_main_off();
        main_div_skip = 1'b0; main_psc_sel = 2'b00; main_div_word = 10'd3;
        repeat (2) @(negedge clk);
        main_en = 1'b1;
        @(negedge clk);
        check("R6 oe set one edge after request", int'(main_oe), 1);
        check("R6 output low at enable", int'(main_clk_o), 0);
        k = 1;
        while (main_clk_o !== 1'b1) begin k++; @(negedge clk); end
        check("R6 main latency", k, 6);

        ref_en = 1'b0;
        @(negedge clk);
        while (ref_oe !== 1'b0) @(negedge clk);
        ref_psc_use = 1'b0;
        @(negedge clk);
        ref_en = 1'b1;
        k = 0;
        @(negedge clk); k++;
        while (ref_clk_o !== 1'b1) begin k++; @(negedge clk); end
        check("R6 ref latency", k, 2);

        // R5: drop request during high phase (half = 3)
        main_div_word = 10'd1;
        expect_period(1, 3, "R2 main word 1 before drain");
        @(negedge clk);
        while (main_clk_o !== 1'b0) @(negedge clk);
        while (main_clk_o !== 1'b1) @(negedge clk);
        main_en = 1'b0;
        hi = 0;
        while (main_clk_o === 1'b1) begin
            hi++;
            check("R5 oe held while high", int'(main_oe), 1);
            @(negedge clk);
        end
        check("R5 high phase not shortened", hi, 3);
        check("R5 oe cleared once low", int'(main_oe), 0);

        // R5: drop request during low phase, no further rise
        main_en = 1'b1;
        @(negedge clk);
        while (main_clk_o !== 1'b1) @(negedge clk);
        while (main_clk_o !== 1'b0) @(negedge clk);
        main_en = 1'b0;
        seen_high = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (main_clk_o === 1'b1) seen_high = 1;
        end
        check("R5 no rise after drop in low phase", int'(seen_high), 0);
        check("R5 oe off after drop in low phase", int'(main_oe), 0);

        // R8: change word in mid high phase (12 -> 2)
        main_div_word = 10'd10;
        main_en = 1'b1;
        @(negedge clk);
        while (main_clk_o !== 1'b1) @(negedge clk);
        hi = 0;
        repeat (2) begin hi++; @(negedge clk); end
        main_div_word = 10'd0;
        while (main_clk_o === 1'b1) begin hi++; @(negedge clk); end
        lo = 0;
        while (main_clk_o === 1'b0) begin lo++; @(negedge clk); end
        check("R8 high phase keeps old length", hi, 12);
        check("R8 low phase keeps old length", lo, 12);
        hi = 0;
        while (main_clk_o === 1'b1) begin hi++; @(negedge clk); end
        check("R8 next period uses new word", hi, 2);

        finish_run();
    end

endmodule